// File: doc/BRIEF.md
# Serial Link Error Monitor and Resync Trigger

This block sits on the receive side of a serial link and inspects each received 34-bit word. The word is 2 overhead bits in `[33:32]` and 32 payload bits in `[31:0]`. A word with overhead `00` belongs to the idle group. The block flags idle words whose payload is corrupted. In cell mode it also checks that the embedded cell marker arrives exactly on the expected cell boundary. A detected error is held in a sticky flag. An external resync enable turns the held error into a one-cycle request to restart link initialization. Separately, a run of four all-zero words forced by the far end requests a restart at once. The initialization sequence itself lies outside this block.

The word input is a valid-only stream. The monitor accepts a word on every cycle in which `word_valid` is high and never applies back-pressure, so it has no ready output. Cycles with `word_valid` low carry no word and are ignored. Error pulses are suppressed while `out_of_sync` is high, so threshold logic outside the block only counts errors on a link that is up.

Top module: `link_err_monitor`

## Requirements
- R1: A valid word with overhead `00` whose payload is neither the idle pattern 0x5A5A5A5A, nor the marker 0xA5A5A5A5, nor zero gives `rx_err` high in the next cycle. This applies only when `out_of_sync` is low. No other word raises `rx_err`.
- R2: With `cell_mode` high, a valid word presented with `cell_end` high that is not the marker gives `cell_err` high in the next cycle. The marker is overhead `00` with payload 0xA5A5A5A5.
- R3: With `cell_mode` high, a valid marker presented with `cell_end` low gives `cell_err` high in the next cycle. With `cell_mode` low, `cell_err` stays low.
- R4: While `out_of_sync` is high or `word_valid` is low, a word raises neither pulse and sets no stored error.
- R5: `err_held` rises together with any error pulse. It then stays high, whatever the following words are, until an init request clears it.
- R6: When `err_held` and `resync_en` are both high in a cycle, `init_start` is high for the next cycle and `err_held` is low in that cycle (unless a new error arrives).
- R7: The fourth consecutive valid word that is entirely zero (all 34 bits) gives `init_start` in the next cycle. This holds whatever the levels of `resync_en` and `out_of_sync`. Cycles with `word_valid` low do not break the run. A valid nonzero word restarts the count.
- R8: After reset (synchronous, active high) all four outputs are low.
- R9: Error pulses last exactly one cycle for each offending word. A valid word followed by an idle cycle leaves the pulse low in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A word is present this cycle |
| word_data | input | 34 | Overhead bits [33:32] and payload [31:0] |
| cell_mode | input | 1 | Enables cell-marker timing checks |
| cell_end | input | 1 | Expected cell boundary for the current word |
| out_of_sync | input | 1 | Link not synchronized; suppresses error pulses |
| resync_en | input | 1 | Allows a stored error to request initialization |
| rx_err | output | 1 | Idle-pattern error pulse |
| cell_err | output | 1 | Cell-marker timing error pulse |
| err_held | output | 1 | Sticky stored-error flag |
| init_start | output | 1 | One-cycle link initialization request |

## Verification
The main check is a sweep. Nine word kinds are each combined with every level of valid, cell mode, boundary strobe and out-of-sync. The nine kinds are good idle, marker, three corrupt idle payloads, all-zero, and data words under the other overhead codes, including one carrying the idle and marker payloads. This separates pattern checking from overhead decoding and marker placement from boundary placement. It also shows that suppression by out-of-sync or a missing valid holds for both pulse kinds. Separate zero-run sequences check the exact fourth-word trigger, the restart on a nonzero word, and that gaps without a valid word leave the run intact.

// File: rtl/lem_pkg.sv
package lem_pkg;
  typedef struct packed {
    logic oh_zero;
    logic all_zero;
    logic idle_ok;
    logic marker;
  } word_class_t;
endpackage

// File: rtl/lem_word_classify.sv
module lem_word_classify
  import lem_pkg::*;
#(
  parameter int OH_W = 2,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IDLE_PAT = 32'h5A5A_5A5A,
  parameter logic [DATA_W-1:0] MARK_PAT = 32'hA5A5_A5A5
) (
  input  logic [OH_W+DATA_W-1:0] word,
  output word_class_t            cls
);
  localparam int W = OH_W + DATA_W;

  logic [OH_W-1:0]   oh;
  logic [DATA_W-1:0] pay;

  assign oh  = word[W-1:DATA_W];
  assign pay = word[DATA_W-1:0];

  always_comb begin
    cls.oh_zero  = (oh == '0);
    cls.all_zero = (word == '0);
    cls.idle_ok  = cls.oh_zero && (pay == IDLE_PAT);
    cls.marker   = cls.oh_zero && (pay == MARK_PAT);
  end
endmodule

// File: rtl/lem_zero_run.sv
module lem_zero_run #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic is_zero,
  input  logic clear,
  output logic hit
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt;

  assign hit = valid && is_zero && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (valid) begin
      if (!is_zero)      cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lem_err_latch.sv
module lem_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_err,
  input  logic zero_hit,
  input  logic resync_en,
  output logic err_held,
  output logic init_start,
  output logic fire
);
  assign fire = (err_held && resync_en) || zero_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_held   <= 1'b0;
      init_start <= 1'b0;
    end else begin
      init_start <= fire;
      if (set_err)   err_held <= 1'b1;
      else if (fire) err_held <= 1'b0;
    end
  end
endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
  import lem_pkg::*;
#(
  parameter int OH_W = 2,
  parameter int DATA_W = 32,
  parameter int ZERO_RUN = 4,
  parameter logic [DATA_W-1:0] IDLE_PAT = 32'h5A5A_5A5A,
  parameter logic [DATA_W-1:0] MARK_PAT = 32'hA5A5_A5A5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   word_valid,
  input  logic [OH_W+DATA_W-1:0] word_data,
  input  logic                   cell_mode,
  input  logic                   cell_end,
  input  logic                   out_of_sync,
  input  logic                   resync_en,
  output logic                   rx_err,
  output logic                   cell_err,
  output logic                   err_held,
  output logic                   init_start
);
  word_class_t cls;
  logic chk, pat_bad, cell_bad, zero_hit, fire;

  lem_word_classify #(
    .OH_W(OH_W), .DATA_W(DATA_W), .IDLE_PAT(IDLE_PAT), .MARK_PAT(MARK_PAT)
  ) u_cls (
    .word(word_data),
    .cls (cls)
  );

  assign chk      = word_valid && !out_of_sync;
  assign pat_bad  = chk && cls.oh_zero && !cls.all_zero && !cls.idle_ok && !cls.marker;
  assign cell_bad = chk && cell_mode && (cell_end ? !cls.marker : cls.marker);

  lem_zero_run #(.RUN_LEN(ZERO_RUN)) u_zr (
    .clk    (clk),
    .rst    (rst),
    .valid  (word_valid),
    .is_zero(cls.all_zero),
    .clear  (fire),
    .hit    (zero_hit)
  );

  lem_err_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .set_err   (pat_bad || cell_bad),
    .zero_hit  (zero_hit),
    .resync_en (resync_en),
    .err_held  (err_held),
    .init_start(init_start),
    .fire      (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_err   <= 1'b0;
      cell_err <= 1'b0;
    end else begin
      rx_err   <= pat_bad;
      cell_err <= cell_bad;
    end
  end
endmodule

module link_err_monitor_chk (
  input logic clk,
  input logic rst,
  input logic word_valid,
  input logic out_of_sync,
  input logic resync_en,
  input logic rx_err,
  input logic cell_err,
  input logic err_held,
  input logic init_start
);
  // R5
  pulse_stored_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_err || cell_err) |-> err_held);
  // R6
  resync_request_chk: assert property (@(posedge clk) disable iff (rst)
    (err_held && resync_en) |=> init_start);
  // R4
  oos_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_of_sync |=> (!rx_err && !cell_err));
  // R4
  no_word_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> (!rx_err && !cell_err));
  // R9
  pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_err && !word_valid) |=> !rx_err);
endmodule

bind link_err_monitor link_err_monitor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_valid (word_valid),
  .out_of_sync(out_of_sync),
  .resync_en  (resync_en),
  .rx_err     (rx_err),
  .cell_err   (cell_err),
  .err_held   (err_held),
  .init_start (init_start)
);

// File: tb/tb_link_err_monitor.sv
module tb_link_err_monitor;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDLE = 32'h5A5A_5A5A;
  localparam logic [31:0] MARK = 32'hA5A5_A5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid = 1'b0;
  logic [33:0] word_data = '0;
  logic cell_mode = 1'b0, cell_end = 1'b0, out_of_sync = 1'b0, resync_en = 1'b0;
  logic rx_err, cell_err, err_held, init_start;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_err_monitor dut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .cell_mode(cell_mode), .cell_end(cell_end), .out_of_sync(out_of_sync),
    .resync_en(resync_en), .rx_err(rx_err), .cell_err(cell_err),
    .err_held(err_held), .init_start(init_start)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; word_valid = 1'b0; resync_en = 1'b0;
    out_of_sync = 1'b0; cell_mode = 1'b0; cell_end = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [33:0] word_of(input int k);
    case (k)
      0: return {2'b00, IDLE};
      1: return {2'b00, MARK};
      2: return {2'b00, 32'h5A5A_5A5B};
      3: return {2'b00, 32'hFFFF_FFFF};
      4: return 34'h0;
      5: return {2'b01, IDLE};
      6: return {2'b10, 32'h0};
      7: return {2'b11, MARK};
      default: return {2'b00, 32'h0000_0001};
    endcase
  endfunction

  task automatic send_zero(input logic v);
    word_valid = v; word_data = '0;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R8 reset state
    check(rx_err, 1'b0, "R8", "rx_err after reset");
    check(cell_err, 1'b0, "R8", "cell_err after reset");
    check(err_held, 1'b0, "R8", "err_held after reset");
    check(init_start, 1'b0, "R8", "init_start after reset");

    // Sweep: R1 R2 R3 R4 R5 R6 R9
    for (int k = 0; k < 9; k++) begin
      for (int m = 0; m < 16; m++) begin
        logic v, cm, ce, oos, bad_pat, is_mark, exp_rx, exp_cell, exp_err;
        do_reset();
        v = m[0]; cm = m[1]; ce = m[2]; oos = m[3];
        bad_pat = (k == 2) || (k == 3) || (k == 8);
        is_mark = (k == 1);
        exp_rx   = v && !oos && bad_pat;
        exp_cell = v && !oos && cm && (ce ? !is_mark : is_mark);
        exp_err  = exp_rx || exp_cell;
        word_valid = v; word_data = word_of(k);
        cell_mode = cm; cell_end = ce; out_of_sync = oos;
        @(negedge clk);
        check(rx_err, exp_rx, "R1", $sformatf("rx_err k=%0d m=%0d", k, m));
        check(cell_err, exp_cell, cm ? (ce ? "R2" : "R3") : "R3",
              $sformatf("cell_err k=%0d m=%0d", k, m));
        check(err_held, exp_err, "R5", $sformatf("err_held set k=%0d m=%0d", k, m));
        word_valid = 1'b0; out_of_sync = 1'b0;
        @(negedge clk);
        check(rx_err, 1'b0, "R9", $sformatf("rx_err drop k=%0d m=%0d", k, m));
        check(err_held, exp_err, "R5", $sformatf("err_held kept k=%0d m=%0d", k, m));
        check(init_start, 1'b0, "R6", $sformatf("no init without enable k=%0d m=%0d", k, m));
        resync_en = 1'b1;
        @(negedge clk);
        check(init_start, exp_err, "R6", $sformatf("init k=%0d m=%0d", k, m));
        check(err_held, 1'b0, "R6", $sformatf("cleared k=%0d m=%0d", k, m));
        resync_en = 1'b0;
      end
    end

    // R5 sticky over good words
    do_reset();
    word_valid = 1'b1; word_data = word_of(3);
    @(negedge clk);
    word_data = word_of(0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(err_held, 1'b1, "R5", "sticky across good idles");
    end

    // R7 exact fourth zero word, enable low, oos high
    do_reset();
    out_of_sync = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send_zero(1'b1);
      check(init_start, i == 3, "R7", $sformatf("zero run index %0d", i));
    end
    word_valid = 1'b0;
    @(negedge clk);
    check(init_start, 1'b0, "R7", "init pulse ends");

    // R7 nonzero word restarts run
    do_reset();
    for (int i = 0; i < 3; i++) send_zero(1'b1);
    word_valid = 1'b1; word_data = word_of(0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      send_zero(1'b1);
      check(init_start, i == 3, "R7", $sformatf("restart index %0d", i));
    end

    // R7 idle gaps keep the run
    do_reset();
    for (int i = 0; i < 4; i++) begin
      send_zero(1'b1);
      check(init_start, i == 3, "R7", $sformatf("gap run index %0d", i));
      send_zero(1'b0);
      check(init_start, 1'b0, "R7", "gap cycle");
    end

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule